// File: doc/BRIEF.md
# CCD Vertical Transfer Burst Controller

This block drives the vertical side of a frame-transfer CCD. On a trigger it waits half a video line and then emits a fixed-length train of transfer pulses. The same train goes to the image-area gate, the storage-area gate and the transfer gate, and a flag marks the span of the burst. Three events start a burst:
- A falling edge on the gate input while vertical drive is low starts a normal frame dump of 244 pulses.
- The same edge while vertical drive is high starts a clear burst of 256 pulses.
- Leaving standby starts a refresh burst of 256 pulses, whatever the gate input is doing.

A speed select picks a fast pulse rate (one pulse every `FAST_PERIOD` master clocks) or a slow rate at half that frequency with an exact 50% duty. While standby is asserted every output is held low and any burst in flight is dropped. In interlace mode a field-parity bit flips at the end of each normal burst. That bit sets the level at which the image-area gate parks between bursts.

Top module: `ccd_vburst_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards with no trigger, all four outputs are low.
- R2: A falling edge on `gate_n` seen while `vdrive` is 0 and `awake` is 1 produces exactly 244 pulses. `stor_clk` and `xfer_clk` carry identical waveforms, and `img_clk` matches them during the burst.
- R3: A falling edge on `gate_n` seen while `vdrive` is 1 produces exactly 256 pulses.
- R4: A rising edge on `awake` produces a refresh burst of exactly 256 pulses while `gate_n` stays high.
- R5: With `dump_fast` = 1 the pulse period is `FAST_PERIOD` (7) clocks, and each pulse is high for the first `FAST_HIGH` (3) clocks of its period.
- R6: With `dump_fast` = 0 the period is 2·`FAST_PERIOD` (14) clocks, and each pulse is high for the first `FAST_PERIOD` (7) clocks (50% duty).
- R7: The first pulse rises `HALF_LINE` (455) clock edges after the edge that registers the trigger.
- R8: `burst_on` is high from the rise of the first pulse to the end of the last pulse period, and is low at every other time.
- R9: Falling edges of `gate_n` that arrive during the start delay or during the burst are ignored. The pulse count and the waveform are unchanged, and no further burst follows.
- R10: While `awake` is 0 all outputs are low, a running burst is abandoned, and gate edges start nothing.
- R11: With `interlace` = 1 the parity flips when a normal burst ends. Between bursts `img_clk` then idles high in even parity and low in odd parity. Clear and refresh bursts leave the parity unchanged. `interlace` = 0 or standby forces odd parity.
- R12: The rate is captured when the trigger is taken, so a change on `dump_fast` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous-free synchronous reset, active low |
| gate_n | input | 1 | Burst gate; a falling edge is a trigger |
| vdrive | input | 1 | Vertical-drive state; 1 selects a clear burst on a gate edge |
| dump_fast | input | 1 | Rate select: 1 fast, 0 half rate |
| awake | input | 1 | 0 = standby, 1 = operate; a rising edge triggers refresh |
| interlace | input | 1 | 1 = alternate field parity on each normal burst |
| img_clk | output | 1 | Image-area transfer clock |
| stor_clk | output | 1 | Storage-area transfer clock |
| xfer_clk | output | 1 | Transfer-gate clock |
| burst_on | output | 1 | High while a burst is running |

## Verification
A trigger is registered at clock edge T. All outputs are combinational on the sequencer state, so the state after edge T+k shows in the same cycle. The pulse train therefore starts after edge T+455 and ends after edge T+455+len·period. The bench applies every stimulus on a falling clock edge and counts k from T. At each falling edge it compares all four outputs with a waveform worked out from k, the period, the high time, the burst length and the expected park level. Standby takes effect combinationally, so the bench checks the outputs at the first falling edge after it drops `awake`.

// File: rtl/ccd_vburst_pkg.sv
`timescale 1ns/1ps
package ccd_vburst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    TRIG_NORMAL  = 2'd0,
    TRIG_CLEAR   = 2'd1,
    TRIG_REFRESH = 2'd2
  } trig_kind_t;

  // clocks per transfer pulse
  function automatic int unsigned pulse_period(input int unsigned fast_period,
                                               input logic fast);
    return fast ? fast_period : 2 * fast_period;
  endfunction

  // clocks the pulse stays high at the start of its period
  function automatic int unsigned pulse_high(input int unsigned fast_period,
                                             input int unsigned fast_high,
                                             input logic fast);
    return fast ? fast_high : fast_period;
  endfunction

  function automatic int unsigned burst_length(input trig_kind_t kind,
                                               input int unsigned normal_len,
                                               input int unsigned clear_len);
    return (kind == TRIG_NORMAL) ? normal_len : clear_len;
  endfunction

endpackage

// File: rtl/ccd_vburst_trig.sv
`timescale 1ns/1ps
module ccd_vburst_trig
  import ccd_vburst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_n,
  input  logic       vdrive,
  input  logic       awake,
  input  logic       busy,
  output logic       fire,
  output trig_kind_t kind
);

  logic gate_q;
  logic awake_q;
  logic wake_evt;
  logic gate_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q  <= 1'b1;
      awake_q <= 1'b1;
    end else begin
      gate_q  <= gate_n;
      awake_q <= awake;
    end
  end

  assign wake_evt  = awake & ~awake_q;
  assign gate_fall = awake & gate_q & ~gate_n & ~busy;
  assign fire      = wake_evt | gate_fall;

  always_comb begin
    if (wake_evt)    kind = TRIG_REFRESH;
    else if (vdrive) kind = TRIG_CLEAR;
    else             kind = TRIG_NORMAL;
  end

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && awake_q && awake) |-> !fire);

  // R10
  sleep_nofire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !fire);

endmodule

// File: rtl/ccd_vburst_seq.sv
`timescale 1ns/1ps
module ccd_vburst_seq
  import ccd_vburst_pkg::*;
#(
  parameter int unsigned FAST_PERIOD = 7,
  parameter int unsigned FAST_HIGH   = 3,
  parameter int unsigned HALF_LINE   = 455,
  parameter int unsigned NORMAL_LEN  = 244,
  parameter int unsigned CLEAR_LEN   = 256
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       awake,
  input  logic       fire,
  input  trig_kind_t kind,
  input  logic       dump_fast,
  output logic       busy,
  output logic       running,
  output logic       phase_hi,
  output logic       burst_start,
  output logic       burst_end,
  output logic       end_normal
);

  localparam int unsigned MAX_LEN = (NORMAL_LEN > CLEAR_LEN) ? NORMAL_LEN : CLEAR_LEN;
  localparam int unsigned DLY_W   = $clog2(HALF_LINE + 1);
  localparam int unsigned PH_W    = $clog2(2 * FAST_PERIOD + 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(HALF_LINE - 1);
  localparam logic [PH_W-1:0]  PH_ONE   = PH_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  seq_state_t       state;
  logic [DLY_W-1:0] dly;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  per_q;
  logic [PH_W-1:0]  hi_q;
  logic [CNT_W-1:0] np;
  logic [CNT_W-1:0] len_q;
  logic             normal_q;
  logic             last_phase;
  logic             last_pulse;

  assign last_phase  = (ph == per_q - PH_ONE);
  assign last_pulse  = (np == len_q - CNT_ONE);
  assign busy        = (state != SEQ_IDLE);
  assign running     = (state == SEQ_RUN);
  assign phase_hi    = running && (ph < hi_q);
  assign burst_start = awake && (state == SEQ_WAIT) && (dly == DLY_LAST);
  assign burst_end   = awake && running && last_phase && last_pulse;
  assign end_normal  = normal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      dly      <= '0;
      ph       <= '0;
      np       <= '0;
      per_q    <= PH_W'(FAST_PERIOD);
      hi_q     <= PH_W'(FAST_HIGH);
      len_q    <= CNT_W'(NORMAL_LEN);
      normal_q <= 1'b0;
    end else if (!awake) begin
      state <= SEQ_IDLE;
      dly   <= '0;
      ph    <= '0;
      np    <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (fire) begin
            state    <= SEQ_WAIT;
            dly      <= '0;
            len_q    <= CNT_W'(burst_length(kind, NORMAL_LEN, CLEAR_LEN));
            per_q    <= PH_W'(pulse_period(FAST_PERIOD, dump_fast));
            hi_q     <= PH_W'(pulse_high(FAST_PERIOD, FAST_HIGH, dump_fast));
            normal_q <= (kind == TRIG_NORMAL);
          end
        end
        SEQ_WAIT: begin
          if (dly == DLY_LAST) begin
            state <= SEQ_RUN;
            ph    <= '0;
            np    <= '0;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        SEQ_RUN: begin
          if (last_phase) begin
            ph <= '0;
            if (last_pulse) state <= SEQ_IDLE;
            else            np    <= np + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R2 R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (np < len_q));

  // R7
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(state) == SEQ_WAIT) |-> ($past(dly) == DLY_LAST));

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (state == SEQ_IDLE));

  // R10
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> (state == SEQ_IDLE));

  // R12
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(per_q) && $stable(hi_q)));

endmodule

// File: rtl/ccd_vburst_drive.sv
`timescale 1ns/1ps
module ccd_vburst_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  input  logic interlace,
  input  logic running,
  input  logic phase_hi,
  input  logic burst_end,
  input  logic end_normal,
  output logic img_clk,
  output logic stor_clk,
  output logic xfer_clk,
  output logic burst_on
);

  logic field_even;
  logic pulse;

  always_ff @(posedge clk) begin
    if (!rst_n)                       field_even <= 1'b0;
    else if (!awake || !interlace)    field_even <= 1'b0;
    else if (burst_end && end_normal) field_even <= ~field_even;
  end

  assign pulse    = awake && phase_hi;
  assign stor_clk = pulse;
  assign xfer_clk = pulse;
  assign img_clk  = awake && (running ? phase_hi : field_even);
  assign burst_on = awake && running;

  // R11
  field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && interlace && burst_end && end_normal) |=> (field_even != $past(field_even)));

  // R11
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && interlace && !burst_end) |=> $stable(field_even));

  // R8
  pulse_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stor_clk |-> burst_on);

endmodule

// File: rtl/ccd_vburst_ctrl.sv
`timescale 1ns/1ps
module ccd_vburst_ctrl
  import ccd_vburst_pkg::*;
#(
  parameter int unsigned FAST_PERIOD = 7,
  parameter int unsigned FAST_HIGH   = 3,
  parameter int unsigned HALF_LINE   = 455,
  parameter int unsigned NORMAL_LEN  = 244,
  parameter int unsigned CLEAR_LEN   = 256
)(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_n,
  input  logic vdrive,
  input  logic dump_fast,
  input  logic awake,
  input  logic interlace,
  output logic img_clk,
  output logic stor_clk,
  output logic xfer_clk,
  output logic burst_on
);

  logic       busy;
  logic       fire;
  trig_kind_t kind;
  logic       running;
  logic       phase_hi;
  logic       burst_start;
  logic       burst_end;
  logic       end_normal;

  ccd_vburst_trig u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_n (gate_n),
    .vdrive (vdrive),
    .awake  (awake),
    .busy   (busy),
    .fire   (fire),
    .kind   (kind)
  );

  ccd_vburst_seq #(
    .FAST_PERIOD (FAST_PERIOD),
    .FAST_HIGH   (FAST_HIGH),
    .HALF_LINE   (HALF_LINE),
    .NORMAL_LEN  (NORMAL_LEN),
    .CLEAR_LEN   (CLEAR_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .awake       (awake),
    .fire        (fire),
    .kind        (kind),
    .dump_fast   (dump_fast),
    .busy        (busy),
    .running     (running),
    .phase_hi    (phase_hi),
    .burst_start (burst_start),
    .burst_end   (burst_end),
    .end_normal  (end_normal)
  );

  ccd_vburst_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .awake      (awake),
    .interlace  (interlace),
    .running    (running),
    .phase_hi   (phase_hi),
    .burst_end  (burst_end),
    .end_normal (end_normal),
    .img_clk    (img_clk),
    .stor_clk   (stor_clk),
    .xfer_clk   (xfer_clk),
    .burst_on   (burst_on)
  );

  // R7
  start_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (burst_on && stor_clk));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stor_clk && !xfer_clk && !burst_on);

endmodule

// File: tb/sim_ccd_vburst_ctrl.sv
`timescale 1ns/1ps
module sim_ccd_vburst_ctrl;

  localparam int FP = 7;
  localparam int FH = 3;
  localparam int HL = 455;

  logic clk = 1'b0;
  logic rst_n, gate_n, vdrive, dump_fast, awake, interlace;
  logic img_clk, stor_clk, xfer_clk, burst_on;
  int vec = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ccd_vburst_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gate_n(gate_n), .vdrive(vdrive),
    .dump_fast(dump_fast), .awake(awake), .interlace(interlace),
    .img_clk(img_clk), .stor_clk(stor_clk), .xfer_clk(xfer_clk),
    .burst_on(burst_on)
  );

  task automatic cmp(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {img_clk, stor_clk, xfer_clk, burst_on};
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {img,stor,xfer,on} got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // mode 0: gate falling edge, mode 1: leave standby
  task automatic burst(input string req, input int mode, input bit vd, input bit fast,
                       input int len, input bit fb, input bit fa,
                       input bit poke, input bit flip);
    int per;
    int hi;
    int rises;
    logic prev;
    per = fast ? FP : 2 * FP;
    hi  = fast ? FH : FP;
    rises = 0;
    prev = 1'b0;
    @(negedge clk);
    vdrive = vd;
    dump_fast = fast;
    if (mode == 0) gate_n = 1'b0;
    else           awake  = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= HL + len * per + 3; k++) begin
      int t;
      logic act, p, ix;
      @(negedge clk);
      t   = k - HL;
      act = (t >= 0) && (t < len * per);
      p   = act && ((t % per) < hi);
      ix  = act ? p : ((t < 0) ? fb : fa);
      cmp(req, {ix, p, p, act});
      if (stor_clk && !prev) rises++;
      prev = stor_clk;
      if (poke && (k == 100 || t == 50)) gate_n = 1'b1;
      if (poke && (k == 101 || t == 51)) gate_n = 1'b0;
      if (flip && t == 20) dump_fast = !fast;
    end
    vec++;
    if (rises != len) begin
      bad++;
      $display("FAIL %s: pulse count got %0d expected %0d", req, rises, len);
    end
    @(negedge clk);
    gate_n = 1'b1;
    dump_fast = fast;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gate_n = 1'b1; vdrive = 1'b0; dump_fast = 1'b1;
    awake = 1'b1; interlace = 1'b0;
    repeat (4) begin
      @(negedge clk);
      cmp("R1 reset", 4'b0000);
    end
    rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      cmp("R1 idle", 4'b0000);
    end

    burst("R2 R5 R7 R8 normal fast", 0, 1'b0, 1'b1, 244, 1'b0, 1'b0, 1'b0, 1'b0);
    burst("R3 R6 clear slow",        0, 1'b1, 1'b0, 256, 1'b0, 1'b0, 1'b0, 1'b0);
    burst("R9 gate edges ignored",   0, 1'b0, 1'b1, 244, 1'b0, 1'b0, 1'b1, 1'b0);
    burst("R12 rate held",           0, 1'b0, 1'b0, 244, 1'b0, 1'b0, 1'b0, 1'b1);

    interlace = 1'b1;
    burst("R11 odd to even",         0, 1'b0, 1'b1, 244, 1'b0, 1'b1, 1'b0, 1'b0);
    burst("R11 clear keeps parity",  0, 1'b1, 1'b1, 256, 1'b1, 1'b1, 1'b0, 1'b0);
    burst("R11 even to odd",         0, 1'b0, 1'b1, 244, 1'b1, 1'b0, 1'b0, 1'b0);
    burst("R11 odd to even again",   0, 1'b0, 1'b1, 244, 1'b0, 1'b1, 1'b0, 1'b0);

    // R10: abandon a running burst, then stay quiet while asleep
    @(negedge clk);
    vdrive = 1'b0;
    gate_n = 1'b0;
    @(posedge clk);
    repeat (HL + 30) @(negedge clk);
    cmp("R10 burst running before sleep", {stor_clk, stor_clk, stor_clk, 1'b1});
    awake = 1'b0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      cmp("R10 standby quiet", 4'b0000);
      if (j == 10) gate_n = 1'b1;
      if (j == 11) gate_n = 1'b0;
      if (j == 20) gate_n = 1'b1;
    end
    burst("R4 refresh on wake",      1, 1'b0, 1'b1, 256, 1'b0, 1'b0, 1'b0, 1'b0);

    interlace = 1'b0;
    burst("R11 noninterlace parks low", 0, 1'b0, 1'b1, 244, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule